// File: doc/BRIEF.md
# Sample DMA Request Controller

This block feeds the one-byte sample buffer of a delta-modulation audio channel from system memory. Whenever that buffer is empty and the current sample run still has bytes left, it waits a short start delay and then raises a memory read request. The read is held until memory acknowledges it. The returned byte is then stored in the buffer, the fetch address moves forward by one and the remaining-byte count goes down by one. When the count runs out, the block either restarts the run from its programmed start (loop mode) or raises an interrupt.

The start delay is two or three clock cycles. The length is picked from the odd/even phase of the channel's rate timer. The choice is reversed when the fetch was set off by a register write that restarted playback rather than by ordinary playback. The output shifter that consumes the buffer sits outside this block. It only returns a strobe each time it takes the byte.

Top module: `dmc_fetch_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), mem_req and sample_full are 0, irq is 0, bytes_left is 0 and mem_addr is 0xC000.
- R2: A kick strobe seen while bytes_left is 0 loads mem_addr with 0xC000 + 64*start_cfg and bytes_left with 16*len_cfg + 1, and marks the run as write-started. A kick seen while bytes_left is nonzero changes neither mem_addr nor bytes_left.
- R3: A fetch is launched only when all of the following hold at a clock edge: the buffer is empty, bytes_left is nonzero, no request is outstanding and no start delay is running. While sample_full is 1, mem_req stays 0.
- R4: For a playback-started fetch, mem_req rises at the N-th clock edge, counting the edge at which the launch conditions and tmr_odd are sampled as the first. N is 3 when tmr_odd is 1 and 2 when it is 0.
- R5: For a write-started fetch, N is 2 when tmr_odd is 1 and 3 when it is 0. The write-started mark clears in the cycle the request is raised, so later fetches use the playback rule.
- R6: Once raised, mem_req stays 1 with mem_addr unchanged until an edge at which mem_ack is 1. After that edge mem_req is 0.
- R7: At an edge with mem_req and mem_ack both 1, mem_data is stored into sample_out, sample_full becomes 1, mem_addr advances by one and bytes_left drops by one.
- R8: Advancing from address 0xFFFF gives 0x8000.
- R9: A consume strobe empties the buffer (sample_full goes to 0 after that edge) unless a fetch completes at the same edge.
- R10: When a completing fetch brings bytes_left to 0 and loop_en is 1, mem_addr and bytes_left reload at once from start_cfg and len_cfg.
- R11: When a completing fetch brings bytes_left to 0 with loop_en 0 and irq_en 1, irq is set. While irq_en is 0, irq is cleared and stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tmr_odd | input | 1 | Rate-timer phase, 1 when the timer value is odd |
| start_cfg | input | 8 | Programmed start address code |
| len_cfg | input | 8 | Programmed length code |
| loop_en | input | 1 | Restart the run when it ends |
| irq_en | input | 1 | Allow the end-of-run interrupt; 0 clears it |
| kick | input | 1 | Register-write strobe that restarts an idle run |
| consume | input | 1 | Output shifter took the buffered byte |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Address of the current or next fetch |
| mem_ack | input | 1 | Memory read completes this cycle |
| mem_data | input | 8 | Byte returned with mem_ack |
| sample_out | output | 8 | Buffered sample byte |
| sample_full | output | 1 | Buffer holds a byte not yet consumed |
| irq | output | 1 | End-of-run interrupt flag |
| bytes_left | output | 12 | Bytes still to fetch in this run |

## Verification
The bench goes after the start delay in all four combinations of timer phase and trigger source. A design that ignored the source, or kept the write mark past the first request, would raise mem_req one cycle early or late. It drives a run across the top of the address space, where a plain increment would fetch from 0x0000. It lets a looping run end, where a missed reload shows bytes_left stuck at 0. It also sends kick strobes into a live run; a design that honoured those would restart the address mid-run. The bench holds the buffer full with no consume strobes and slows memory acknowledges, which exposes any request raised over an unconsumed byte or any address that drifts while a read is pending.

// File: rtl/dmc_fetch_pkg.sv
// Shared definitions for the sample fetch controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dmc_fetch_pkg;

    // Which event set off the run that the next fetch belongs to.
    typedef enum logic {
        SRC_PLAYBACK = 1'b0,
        SRC_WRITE    = 1'b1
    } fetch_src_e;

    // True when the longer of the two start delays applies.
    function automatic logic use_long_delay(input logic odd, input fetch_src_e src);
        return odd ^ (src == SRC_WRITE);
    endfunction

endpackage

// File: rtl/dmc_launch_timer.sv
// Start-delay counter. When armed with the counter idle, it loads a delay
// of SHORT_DLY or LONG_DLY cycles and pulses issue in the last cycle.
// Assumes: SHORT_DLY >= 2 and LONG_DLY >= 2; arm already excludes the case
// of a request being outstanding.
module dmc_launch_timer
    import dmc_fetch_pkg::*;
#(
    parameter int SHORT_DLY = 2,
    parameter int LONG_DLY  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       tmr_odd,
    input  fetch_src_e src,
    output logic       busy,
    output logic       issue
);
    localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int DLY_W   = $clog2(MAX_DLY + 1);
    localparam logic [DLY_W-1:0] LOAD_SHORT = DLY_W'(SHORT_DLY - 1);
    localparam logic [DLY_W-1:0] LOAD_LONG  = DLY_W'(LONG_DLY - 1);

    logic [DLY_W-1:0] cnt;

    assign busy  = (cnt != '0);
    assign issue = (cnt == DLY_W'(1));

    // Load the delay on arm, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - DLY_W'(1);
        end else if (arm) begin
            cnt <= use_long_delay(tmr_odd, src) ? LOAD_LONG : LOAD_SHORT;
        end
    end
endmodule

// File: rtl/dmc_addr_len.sv
// Fetch address and remaining-length tracker. Loads both on an accepted
// kick, advances on each completed fetch with wrap to WRAP_ADDR, and
// reloads at the end of a run when looping.
// Assumes: ALIGN_SH + CFG_W <= ADDR_W; advance and an accepted kick never
// coincide (an accepted kick needs zero remaining, advance needs nonzero).
module dmc_addr_len #(
    parameter int              ADDR_W    = 16,
    parameter int              CFG_W     = 8,
    parameter int              ALIGN_SH  = 6,
    parameter int              LEN_SH    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000,
    parameter logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000,
    localparam int             LEN_W     = CFG_W + LEN_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [CFG_W-1:0]  start_cfg,
    input  logic [CFG_W-1:0]  len_cfg,
    input  logic              loop_en,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  remain,
    output logic              kick_taken,
    output logic              run_done
);
    // Start address for a given code.
    function automatic logic [ADDR_W-1:0] start_of(input logic [CFG_W-1:0] c);
        logic [ADDR_W-1:0] off;
        off = '0;
        off[ALIGN_SH +: CFG_W] = c;
        return BASE_ADDR + off;
    endfunction

    // Byte count for a given code.
    function automatic logic [LEN_W-1:0] len_of(input logic [CFG_W-1:0] c);
        logic [LEN_W-1:0] l;
        l = '0;
        l[LEN_SH +: CFG_W] = c;
        return l + LEN_W'(1);
    endfunction

    logic              last_byte;
    logic [ADDR_W-1:0] addr_inc;

    assign last_byte  = (remain == LEN_W'(1));
    assign addr_inc   = (addr == '1) ? WRAP_ADDR : addr + ADDR_W'(1);
    assign kick_taken = kick && (remain == '0);
    assign run_done   = advance && last_byte && !loop_en;

    // Address and count update: fetch completion first, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= BASE_ADDR;
            remain <= '0;
        end else if (advance) begin
            if (last_byte && loop_en) begin
                addr   <= start_of(start_cfg);
                remain <= len_of(len_cfg);
            end else begin
                addr   <= addr_inc;
                remain <= remain - LEN_W'(1);
            end
        end else if (kick_taken) begin
            addr   <= start_of(start_cfg);
            remain <= len_of(len_cfg);
        end
    end
endmodule

// File: rtl/dmc_sample_hold.sv
// One-byte sample buffer with a full flag. A load sets it full and
// takes priority over a take strobe in the same cycle.
// Assumes: load is only asserted while a fetch completes.
module dmc_sample_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic [DATA_W-1:0] dout,
    output logic              full
);
    // Capture fetched bytes and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            full <= 1'b0;
        end else if (load) begin
            dout <= din;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/dmc_fetch_ctrl.sv
// Sample fetch controller top. Watches the sample buffer, launches a read
// after a phase-dependent start delay, holds the request until acknowledged,
// and raises an end-of-run interrupt when not looping.
// Assumes: mem_ack is only meaningful while mem_req is high; mem_data is
// valid in the cycle of mem_ack.
module dmc_fetch_ctrl
    import dmc_fetch_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              CFG_W     = 8,
    parameter int              ALIGN_SH  = 6,
    parameter int              LEN_SH    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hC000,
    parameter logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000,
    parameter int              SHORT_DLY = 2,
    parameter int              LONG_DLY  = 3,
    localparam int             LEN_W     = CFG_W + LEN_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_odd,
    input  logic [CFG_W-1:0]  start_cfg,
    input  logic [CFG_W-1:0]  len_cfg,
    input  logic              loop_en,
    input  logic              irq_en,
    input  logic              kick,
    input  logic              consume,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] sample_out,
    output logic              sample_full,
    output logic              irq,
    output logic [LEN_W-1:0]  bytes_left
);
    fetch_src_e src_q;
    logic       req_q;
    logic       irq_q;
    logic       dly_busy;
    logic       dly_issue;
    logic       arm;
    logic       fetch_done;
    logic       kick_taken;
    logic       run_done;

    assign fetch_done = req_q && mem_ack;
    assign arm        = !sample_full && (bytes_left != '0) && !req_q && !dly_busy;

    dmc_launch_timer #(
        .SHORT_DLY (SHORT_DLY),
        .LONG_DLY  (LONG_DLY)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .tmr_odd (tmr_odd),
        .src     (src_q),
        .busy    (dly_busy),
        .issue   (dly_issue)
    );

    dmc_addr_len #(
        .ADDR_W    (ADDR_W),
        .CFG_W     (CFG_W),
        .ALIGN_SH  (ALIGN_SH),
        .LEN_SH    (LEN_SH),
        .BASE_ADDR (BASE_ADDR),
        .WRAP_ADDR (WRAP_ADDR)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (kick),
        .start_cfg  (start_cfg),
        .len_cfg    (len_cfg),
        .loop_en    (loop_en),
        .advance    (fetch_done),
        .addr       (mem_addr),
        .remain     (bytes_left),
        .kick_taken (kick_taken),
        .run_done   (run_done)
    );

    dmc_sample_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fetch_done),
        .din   (mem_data),
        .take  (consume),
        .dout  (sample_out),
        .full  (sample_full)
    );

    // Request line: raised when the delay expires, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (dly_issue) begin
            req_q <= 1'b1;
        end else if (fetch_done) begin
            req_q <= 1'b0;
        end
    end

    // Trigger-source mark: set by an accepted kick, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_PLAYBACK;
        end else if (kick_taken) begin
            src_q <= SRC_WRITE;
        end else if (dly_issue) begin
            src_q <= SRC_PLAYBACK;
        end
    end

    // Interrupt flag: set at a non-looping run end, held clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (!irq_en) begin
            irq_q <= 1'b0;
        end else if (run_done) begin
            irq_q <= 1'b1;
        end
    end

    assign mem_req = req_q;
    assign irq     = irq_q;
endmodule

// File: rtl/dmc_fetch_chk.sv
// Property checker for the sample fetch controller, bound to its top.
// Assumes: observes ports only.
module dmc_fetch_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              kick,
    input logic              consume,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_data,
    input logic [DATA_W-1:0] sample_out,
    input logic              sample_full,
    input logic              irq,
    input logic [LEN_W-1:0]  bytes_left
);
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    assert_no_req_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_full |-> !mem_req);

    assert_launch_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (bytes_left != '0) && !sample_full);

    assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> sample_full && (sample_out == $past(mem_data)));

    assert_consume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !(mem_req && mem_ack) |=> !sample_full);

    assert_kick_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick && (bytes_left != '0) && !(mem_req && mem_ack) |=> $stable(bytes_left) && $stable(mem_addr));

    assert_addr_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[ADDR_W-1]);

    assert_irq_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);
endmodule

bind dmc_fetch_ctrl dmc_fetch_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_en      (irq_en),
    .kick        (kick),
    .consume     (consume),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_data    (mem_data),
    .sample_out  (sample_out),
    .sample_full (sample_full),
    .irq         (irq),
    .bytes_left  (bytes_left)
);

// File: tb/tb_dmc_fetch_ctrl.sv
// Bench for the sample fetch controller: behavioural reference model
// compared on every clock, plus directed checks per requirement.
module tb_dmc_fetch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_odd = 1'b0;
    logic [7:0]  start_cfg = 8'h00;
    logic [7:0]  len_cfg = 8'h00;
    logic        loop_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        kick = 1'b0;
    logic        consume = 1'b0;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_data = 8'h00;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  sample_out;
    logic        sample_full;
    logic        irq;
    logic [11:0] bytes_left;

    always #4 clk = ~clk;

    dmc_fetch_ctrl dut (
        .clk (clk), .rst_n (rst_n), .tmr_odd (tmr_odd),
        .start_cfg (start_cfg), .len_cfg (len_cfg), .loop_en (loop_en),
        .irq_en (irq_en), .kick (kick), .consume (consume),
        .mem_req (mem_req), .mem_addr (mem_addr), .mem_ack (mem_ack),
        .mem_data (mem_data), .sample_out (sample_out),
        .sample_full (sample_full), .irq (irq), .bytes_left (bytes_left)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    int m_addr, m_rem, m_buf, m_wait, r_cnt, lat;
    bit m_full, m_req, m_fw, m_irq;

    function automatic int mem_byte(input int a);
        return ((a & 255) ^ 90) + ((a >> 8) & 255) & 255;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_tick();
        int n_addr = m_addr, n_rem = m_rem, n_buf = m_buf, n_wait = m_wait;
        bit n_full = m_full, n_req = m_req, n_fw = m_fw, n_irq = m_irq;
        if (!rst_n) begin
            m_addr = 'hC000; m_rem = 0; m_buf = 0; m_wait = 0;
            m_full = 0; m_req = 0; m_fw = 0; m_irq = 0;
            return;
        end
        if (m_wait > 0) begin
            n_wait = m_wait - 1;
            if (n_wait == 0) begin n_req = 1; n_fw = 0; end
        end else if (!m_full && m_rem != 0 && !m_req) begin
            n_wait = ((tmr_odd ^ m_fw) ? 3 : 2) - 1;
        end
        if (consume) n_full = 0;
        if (m_req && mem_ack) begin
            n_buf = mem_data; n_full = 1; n_req = 0;
            n_addr = (m_addr == 'hFFFF) ? 'h8000 : m_addr + 1;
            n_rem = m_rem - 1;
            if (n_rem == 0) begin
                if (loop_en) begin
                    n_addr = 'hC000 + 64 * start_cfg; n_rem = 16 * len_cfg + 1;
                end else if (irq_en) n_irq = 1;
            end
        end
        if (kick && m_rem == 0) begin
            n_addr = 'hC000 + 64 * start_cfg; n_rem = 16 * len_cfg + 1; n_fw = 1;
        end
        if (!irq_en) n_irq = 0;
        m_addr = n_addr; m_rem = n_rem; m_buf = n_buf; m_wait = n_wait;
        m_full = n_full; m_req = n_req; m_fw = n_fw; m_irq = n_irq;
    endtask

    // One clock: drive memory response, advance model, compare at +1.
    task automatic step();
        mem_ack  = m_req && (r_cnt >= lat);
        mem_data = 8'(mem_byte(m_addr));
        model_tick();
        r_cnt = m_req ? r_cnt + 1 : 0;
        @(posedge clk);
        #1;
        chk(mem_req == m_req, "R4", "mem_req", int'(mem_req), int'(m_req));
        chk(int'(mem_addr) == m_addr, "R6", "mem_addr", int'(mem_addr), m_addr);
        chk(int'(sample_out) == m_buf, "R7", "sample_out", int'(sample_out), m_buf);
        chk(sample_full == m_full, "R9", "sample_full", int'(sample_full), int'(m_full));
        chk(irq == m_irq, "R11", "irq", int'(irq), int'(m_irq));
        chk(int'(bytes_left) == m_rem, "R10", "bytes_left", int'(bytes_left), m_rem);
        mem_ack = 1'b0;
    endtask

    // Steps after a trigger step until mem_req is seen.
    task automatic wait_req(input int exp, input string tag);
        int n = 0;
        while (!mem_req && n < 10) begin
            step();
            n++;
        end
        chk(n == exp, tag, "start delay", n, exp);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            consume = m_full;
            step();
        end
        consume = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit wrap_seen, reload_seen;
        int prev_left;
        lat = 0; r_cnt = 0;
        m_addr = 'hC000; m_rem = 0; m_buf = 0; m_wait = 0;
        m_full = 0; m_req = 0; m_fw = 0; m_irq = 0;
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk(!mem_req && !sample_full && !irq, "R1", "flags", {mem_req, sample_full, irq}, 0);
        chk(bytes_left == 0 && mem_addr == 16'hC000, "R1", "addr", int'(mem_addr), 'hC000);

        // R2 kick loads run; R5 write-start even phase gives 3
        start_cfg = 8'h02; len_cfg = 8'h01; irq_en = 1'b1; tmr_odd = 1'b0; lat = 5;
        kick = 1'b1; step(); kick = 1'b0;
        chk(bytes_left == 17, "R2", "length load", int'(bytes_left), 17);
        chk(mem_addr == 16'hC080, "R2", "address load", int'(mem_addr), 'hC080);
        wait_req(3, "R5");
        lat = 2;
        repeat (3) step();
        chk(sample_full && sample_out == 8'(mem_byte('hC080)), "R7", "fetched byte",
            int'(sample_out), mem_byte('hC080));
        chk(bytes_left == 16 && mem_addr == 16'hC081, "R7", "advance", int'(mem_addr), 'hC081);

        // R3 full buffer holds off requests
        for (int i = 0; i < 8; i++) begin
            step();
            chk(!mem_req, "R3", "req while full", int'(mem_req), 0);
        end

        // R4 playback, even phase gives 2 (write mark already cleared, R5)
        lat = 0;
        consume = 1'b1; step(); consume = 1'b0;
        wait_req(2, "R4");
        step();
        // R4 playback, odd phase gives 3
        tmr_odd = 1'b1;
        consume = 1'b1; step(); consume = 1'b0;
        wait_req(3, "R4");
        step();

        // R2 kick during a live run is ignored
        kick = 1'b1; step(); kick = 1'b0;
        chk(bytes_left == 14, "R2", "kick ignored", int'(bytes_left), 14);

        // R11 end of run raises irq, irq_en low clears it
        run(120);
        chk(bytes_left == 0 && irq, "R11", "irq at end", int'(irq), 1);
        irq_en = 1'b0; step();
        chk(!irq, "R11", "irq cleared", int'(irq), 0);

        // R5 write-start odd phase gives 2
        tmr_odd = 1'b1;
        consume = 1'b1; kick = 1'b1; step(); consume = 1'b0; kick = 1'b0;
        wait_req(2, "R5");
        run(120);
        chk(!irq && bytes_left == 0, "R11", "irq stays off", int'(irq), 0);

        // R8 wrap and R10 loop reload
        start_cfg = 8'hFF; len_cfg = 8'h04; loop_en = 1'b1; lat = 1; tmr_odd = 1'b0;
        kick = 1'b1; step(); kick = 1'b0;
        wrap_seen = 0; reload_seen = 0;
        prev_left = int'(bytes_left);
        for (int i = 0; i < 500; i++) begin
            consume = m_full;
            step();
            if (mem_addr == 16'h8000) wrap_seen = 1;
            if (prev_left == 1 && bytes_left == 65 && mem_addr == 16'hFFC0) reload_seen = 1;
            prev_left = int'(bytes_left);
        end
        consume = 1'b0;
        chk(wrap_seen, "R8", "wrap to 8000", int'(wrap_seen), 1);
        chk(reload_seen, "R10", "loop reload", int'(reload_seen), 1);

        loop_en = 1'b0; irq_en = 1'b1;
        run(400);
        chk(irq && bytes_left == 0, "R11", "irq after loop off", int'(irq), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule